// File: doc/BRIEF.md
# Timer Capture Channel with Tick-Synchronized Event Delivery

This block is a single capture channel that sits beside a free-running timer counter. Software programs it through a small register port. It picks one of two external capture inputs, or a fixed level, and watches that signal for rising edges, falling edges or both. On a qualifying edge it latches the current counter value, raises a status flag and, when enabled, drives an interrupt request. Edge detection stays armed whenever capture is switched on, even while the counter is stopped.

An optional synchronize setting holds a detected edge as a pending event. The event is delivered on the next timer tick, the tick being the enable that also advances the counter. Without ticks the event can stay pending for any length of time. Software can force a capture by changing the input select or edge mode while capture is on. Switching capture on in the same write only records the input level as the starting reference. Writing the channel control word to zero disarms the channel and throws away any pending event, so a later restart never reports stale history.

Top module: `tmr_capture_unit`

## Requirements
- R1: After reset every register reads 0 and the interrupt request is low.
- R2: Timer control bits 5:4 set the run mode. The value 2 advances the counter by one on each cycle with the tick input high, wrapping at the top. Any other value holds the counter.
- R3: Channel control bits 15:14 pick the edges (0 none, 1 rising, 2 falling, 3 both). Bits 13:12 pick the source (0 input A, 1 input B, 2 constant low, 3 constant high).
- R4: With capture on (bit 8), a qualifying edge latches the counter value into the capture register and sets the flag (bit 0). This happens whether or not the counter is running.
- R5: With synchronize (bit 11) clear, the flag is set on the third rising clock edge after the input pin changes: two synchronizer stages, then one register stage. The tick input plays no part.
- R6: With synchronize set, a detected edge is held pending. It is captured and flagged on the first later clock edge with the tick high, and it stays pending indefinitely while the tick stays low.
- R7: A write that takes capture from off to on produces no flag, whatever select and edge mode it writes. It loads the selected level as the reference.
- R8: With capture already on, a write that makes the selected level differ from the reference counts as an edge and captures. A write that leaves the level unchanged does not.
- R9: A write with bit 8 clear discards a pending synchronized event. A write that only clears the flag leaves a pending event in place, and a later tick still sets the flag.
- R10: A capture while the flag is already set sets the overflow bit (bit 1). Software writing 0 to that bit clears it. Writing 1 to it leaves it unchanged.
- R11: The interrupt request is high exactly when the flag and the interrupt enable (bit 4) are both set.
- R12: Address 0 is timer control, 1 is channel control, 2 is the capture value and 3 is the counter. Addresses 2 and 3 are read-only, and writes to them change nothing. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Timer clock tick enable |
| capInA | input | 1 | Capture source A, asynchronous |
| capInB | input | 1 | Capture source B, asynchronous |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit counter and a two-stage input synchronizer. The full-width counter lets the bench check wrap-free capture values against a counter it tracks itself from the ticks it applies. The two-stage depth fixes the edge-to-flag latency at three clock edges, which is the timing the directed checks on synchronized and unsynchronized delivery rely on.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  localparam int REG_W = 16;

  localparam logic [1:0] ADDR_TMR  = 2'd0;
  localparam logic [1:0] ADDR_CHAN = 2'd1;
  localparam logic [1:0] ADDR_CAPV = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;

  localparam int B_FLAG  = 0;
  localparam int B_OVF   = 1;
  localparam int B_IE    = 4;
  localparam int B_CAPON = 8;
  localparam int B_SYNC  = 11;

  localparam logic [1:0] RUN_CONT = 2'd2;

  typedef struct packed {
    logic cntAdv;   // advance the counter this cycle
    logic capLoad;  // latch the counter into the capture register
  } tcap_strobe_t;

  function automatic logic pickLevel(input logic [1:0] sel, input logic a, input logic b);
    case (sel)
      2'd0:    pickLevel = a;
      2'd1:    pickLevel = b;
      2'd2:    pickLevel = 1'b0;
      default: pickLevel = 1'b1;
    endcase
  endfunction

  function automatic logic edgeQualifies(input logic [1:0] mode, input logic prev, input logic cur);
    edgeQualifies = (prev != cur) && (cur ? mode[0] : mode[1]);
  endfunction

endpackage

// File: rtl/tcap_datapath.sv
module tcap_datapath
  import tcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawA,
  input  logic             rawB,
  input  tcap_strobe_t     strb,
  output logic             levelA,
  output logic             levelB,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] capVal
);

  localparam int N_IN = 2;

  logic [N_IN-1:0] rawVec;
  logic [N_IN-1:0] syncOut;

  assign rawVec = {rawB, rawA};

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_sync
    logic [SYNC_STAGES-1:0] shReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shReg <= '0;
      else if (SYNC_STAGES == 1) shReg <= rawVec[gi];
      else shReg <= {shReg[SYNC_STAGES-2:0], rawVec[gi]};
    end
    assign syncOut[gi] = shReg[SYNC_STAGES-1];
  end

  assign levelA = syncOut[0];
  assign levelB = syncOut[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntVal <= '0;
    else if (strb.cntAdv) cntVal <= cntVal + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capVal <= '0;
    else if (strb.capLoad) capVal <= cntVal;
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntAdv |=> $stable(cntVal));

  // R4
  cap_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capLoad |=> (capVal == $past(cntVal)));

endmodule

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
  import tcap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic             levelA,
  input  logic             levelB,
  output tcap_strobe_t     strb,
  output logic [REG_W-1:0] chanWord,
  output logic [REG_W-1:0] tmrWord,
  output logic             irq
);

  logic [1:0] edgeMode, inSel, runMode;
  logic       syncOn, capOn, intEn, flag, ovf, refLvl, pend;

  logic wrChan, wrTmr, killEvt, curLvl, edgeHit, capFire, armNow;

  assign wrChan  = regWr && (regAddr == ADDR_CHAN);
  assign wrTmr   = regWr && (regAddr == ADDR_TMR);
  assign killEvt = wrChan && !regWrData[B_CAPON];
  assign armNow  = wrChan && regWrData[B_CAPON] && !capOn;

  assign curLvl  = pickLevel(inSel, levelA, levelB);
  assign edgeHit = capOn && edgeQualifies(edgeMode, refLvl, curLvl);
  assign capFire = !killEvt && capOn && (edgeHit || pend) && (!syncOn || tickEn);

  assign strb.capLoad = capFire;
  assign strb.cntAdv  = tickEn && (runMode == RUN_CONT);

  // channel configuration fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeMode <= '0;
      inSel    <= '0;
      syncOn   <= 1'b0;
      capOn    <= 1'b0;
      intEn    <= 1'b0;
    end else if (wrChan) begin
      edgeMode <= regWrData[15:14];
      inSel    <= regWrData[13:12];
      syncOn   <= regWrData[B_SYNC];
      capOn    <= regWrData[B_CAPON];
      intEn    <= regWrData[B_IE];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runMode <= '0;
    else if (wrTmr) runMode <= regWrData[5:4];
  end

  // reference level for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refLvl <= 1'b0;
    else if (armNow) refLvl <= pickLevel(regWrData[13:12], levelA, levelB);
    else if (capOn) refLvl <= curLvl;
  end

  // pending synchronized event
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pend <= 1'b0;
    else if (killEvt || capFire) pend <= 1'b0;
    else if (edgeHit) pend <= 1'b1;
  end

  // status bits: hardware set wins over a software write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (capFire) flag <= 1'b1;
      else if (wrChan) flag <= regWrData[B_FLAG];
      if (capFire && flag) ovf <= 1'b1;
      else if (wrChan) ovf <= ovf & regWrData[B_OVF];
    end
  end

  always_comb begin
    chanWord            = '0;
    chanWord[15:14]     = edgeMode;
    chanWord[13:12]     = inSel;
    chanWord[B_SYNC]    = syncOn;
    chanWord[B_CAPON]   = capOn;
    chanWord[B_IE]      = intEn;
    chanWord[B_OVF]     = ovf;
    chanWord[B_FLAG]    = flag;
    tmrWord             = '0;
    tmrWord[5:4]        = runMode;
  end

  assign irq = flag & intEn;

  // R6
  sync_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncOn && capFire) |-> tickEn);

  // R9
  pend_discard_chk: assert property (@(posedge clk) disable iff (!rstN)
    killEvt |=> !pend);

  // R10
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovf) |-> $past(flag));

  // R7
  arm_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armNow && !flag && !regWrData[B_FLAG]) |=> !flag);

endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import tcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        capInA,
  input  logic        capInB,
  input  logic        regWr,
  input  logic [1:0]  regAddr,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  output logic        irq
);

  tcap_strobe_t     strb;
  logic             levelA, levelB;
  logic [CNT_W-1:0] cntVal, capVal;
  logic [REG_W-1:0] chanWord, tmrWord;

  tcap_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .levelA    (levelA),
    .levelB    (levelB),
    .strb      (strb),
    .chanWord  (chanWord),
    .tmrWord   (tmrWord),
    .irq       (irq)
  );

  tcap_datapath #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .rawA   (capInA),
    .rawB   (capInB),
    .strb   (strb),
    .levelA (levelA),
    .levelB (levelB),
    .cntVal (cntVal),
    .capVal (capVal)
  );

  always_comb begin
    case (regAddr)
      ADDR_TMR:  regRdData = tmrWord;
      ADDR_CHAN: regRdData = chanWord;
      ADDR_CAPV: regRdData = REG_W'(capVal);
      default:   regRdData = REG_W'(cntVal);
    endcase
  end

endmodule

// File: tb/tmr_capture_unit_tb.sv
module tmr_capture_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        capInA = 1'b0;
  logic        capInB = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  logic [15:0] expCnt = 16'd0;
  logic        expRun = 1'b0;

  always #2 clk = ~clk;

  tmr_capture_unit u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .capInA(capInA), .capInB(capInB),
    .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  function automatic logic qualifies(input logic [1:0] mode, input logic prev, input logic cur);
    if (prev == cur) return 1'b0;
    if (cur) return (mode == 2'd1) || (mode == 2'd3);
    return (mode == 2'd2) || (mode == 2'd3);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic step(input logic t);
    tickEn = t;
    @(posedge clk);
    if (t && expRun) expCnt = expCnt + 16'd1;
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic steps(input int n, input logic t);
    for (int i = 0; i < n; i++) step(t);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    regWr = 1'b1; regAddr = a; regWrData = d;
    if (a == 2'd0) expRun = (d[5:4] == 2'd2);
    step(1'b0);
    regWr = 1'b0; regWrData = 16'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic chkFlag(input string tag, input logic exp);
    logic [15:0] v;
    rd(2'd1, v);
    check(tag, {15'd0, v[0]}, {15'd0, exp});
  endtask

  task automatic chkReg(input string tag, input logic [1:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin : watchdog
    #800000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    logic [15:0] snap;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) chkReg("R1 reset reg", 2'(a), 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'd0);

    // R12 read-only addresses
    wr(2'd2, 16'hFFFF);
    wr(2'd3, 16'hFFFF);
    chkReg("R12 capv ro", 2'd2, 16'h0000);
    chkReg("R12 cnt ro", 2'd3, 16'h0000);

    // R2 counter run and hold
    wr(2'd0, 16'h0020);
    chkReg("R2 tmr readback", 2'd0, 16'h0020);
    steps(5, 1'b1);
    chkReg("R2 count", 2'd3, expCnt);
    check("R2 count value", expCnt, 16'd5);
    steps(3, 1'b0);
    chkReg("R2 no tick hold", 2'd3, 16'd5);
    wr(2'd0, 16'h0000);
    steps(2, 1'b1);
    chkReg("R2 stopped hold", 2'd3, 16'd5);
    wr(2'd0, 16'h0010);
    steps(2, 1'b1);
    chkReg("R2 mode1 hold", 2'd3, 16'd5);
    wr(2'd0, 16'h0000);

    // R4/R5 capture with counter stopped, rising only
    wr(2'd1, 16'h4100);
    chkFlag("R7 arm no flag", 1'b0);
    steps(2, 1'b0);
    capInA = 1'b1;
    steps(2, 1'b0);
    chkFlag("R5 not before third edge", 1'b0);
    step(1'b0);
    chkFlag("R5 flag on third edge", 1'b1);
    chkReg("R4 captured while stopped", 2'd2, 16'd5);
    check("R11 irq off without enable", {15'd0, irq}, 16'd0);
    wr(2'd1, 16'h4110);
    chkFlag("R4 flag cleared", 1'b0);
    capInA = 1'b0;
    steps(3, 1'b0);
    chkFlag("R3 falling ignored in rising mode", 1'b0);

    // R8 mode change without level change, R10 overflow
    wr(2'd1, 16'hC110);
    steps(3, 1'b0);
    chkFlag("R8 no capture without level change", 1'b0);
    capInA = 1'b1;
    steps(3, 1'b0);
    chkFlag("R3 both edges rise", 1'b1);
    check("R11 irq high", {15'd0, irq}, 16'd1);
    capInA = 1'b0;
    steps(3, 1'b0);
    chkReg("R10 overflow set", 2'd1, 16'hC113);
    wr(2'd1, 16'hC112);
    chkReg("R10 ovf kept by writing 1", 2'd1, 16'hC112);
    check("R11 irq low after clear", {15'd0, irq}, 16'd0);
    wr(2'd1, 16'hC110);
    chkReg("R10 ovf cleared by 0", 2'd1, 16'hC110);

    // R8 software-triggered capture via select change
    wr(2'd0, 16'h0020);
    steps(7, 1'b1);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'hF110);
    chkFlag("R8 not yet", 1'b0);
    step(1'b0);
    chkFlag("R8 select change captures", 1'b1);
    chkReg("R8 capture value", 2'd2, expCnt);

    // R7 arming with new select does not flag
    wr(2'd1, 16'h0000);
    capInB = 1'b1;
    steps(3, 1'b0);
    wr(2'd1, 16'hD110);
    steps(3, 1'b0);
    chkFlag("R7 arm on B high no flag", 1'b0);
    capInB = 1'b0;
    steps(3, 1'b0);
    chkFlag("R3 input B falling", 1'b1);
    wr(2'd1, 16'h0000);
    wr(2'd1, 16'hF110);
    steps(3, 1'b0);
    chkFlag("R7 arm on constant high no flag", 1'b0);

    // R6 synchronized delivery
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0020);
    wr(2'd1, 16'hC910);
    capInA = 1'b1;
    steps(13, 1'b0);
    chkFlag("R6 pending without tick", 1'b0);
    check("R6 irq quiet while pending", {15'd0, irq}, 16'd0);
    snap = expCnt;
    step(1'b1);
    chkFlag("R6 delivered on tick", 1'b1);
    chkReg("R6 capture value", 2'd2, snap);
    chkReg("R2 counter advanced", 2'd3, snap + 16'd1);

    // R9 flag-only clear keeps pending
    capInA = 1'b0;
    steps(4, 1'b0);
    wr(2'd1, 16'hC910);
    steps(2, 1'b0);
    chkFlag("R9 cleared flag stays low", 1'b0);
    step(1'b1);
    chkFlag("R9 pending survives flag clear", 1'b1);
    // R9 disable discards pending
    capInA = 1'b1;
    steps(4, 1'b0);
    wr(2'd1, 16'h0000);
    wr(2'd1, 16'hC910);
    steps(3, 1'b1);
    chkFlag("R9 discarded after disable", 1'b0);

    // Random: edges on a chosen source, counter running with random ticks
    wr(2'd1, 16'h0000);
    for (int it = 0; it < 40; it++) begin
      logic [1:0] mode;
      logic       useB, lvl0, lvl1, fire;
      logic [15:0] cs;
      mode = 2'($urandom_range(0, 3));
      useB = 1'($urandom_range(0, 1));
      lvl0 = 1'($urandom_range(0, 1));
      lvl1 = 1'($urandom_range(0, 1));
      wr(2'd1, 16'h0000);
      if (useB) capInB = lvl0; else capInA = lvl0;
      if (useB) capInA = 1'($urandom_range(0, 1)); else capInB = 1'($urandom_range(0, 1));
      steps(3, 1'b0);
      wr(2'd1, {mode, 1'b0, useB, 4'h1, 8'h10});
      steps(3, 1'($urandom_range(0, 1)));
      chkFlag("R7 random arm quiet", 1'b0);
      if (useB) capInB = lvl1; else capInA = lvl1;
      if (useB) capInA = ~capInA; else capInB = ~capInB;
      step(1'($urandom_range(0, 1)));
      step(1'($urandom_range(0, 1)));
      cs = expCnt;
      step(1'($urandom_range(0, 1)));
      fire = qualifies(mode, lvl0, lvl1);
      chkFlag("R3 random edge mode", fire);
      check("R11 random irq", {15'd0, irq}, {15'd0, fire});
      if (fire) chkReg("R4 random capture value", 2'd2, cs);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule